// File: doc/BRIEF.md
# Audio Decoder Host Reset Sequencer

This block sits on the host side of an external audio decoder and runs its bring-up and shutdown sequences. It owns the decoder's active-low hardware reset line and watches the decoder's data-request line (DREQ) through a two-flop synchroniser. It talks to the decoder through three abstract ports. A control write port uses request/acknowledge and carries a 4-bit register address and 16 bits of data. A read port with the same handshake fetches the header-status register. A byte port uses valid/ready and pushes zero bytes into the decoder's data input.

Three command pulses start the sequences:
- **Initialise** pulses the hardware reset. It then waits for DREQ, sets the clock multiplier to 3.0 and writes the basic configuration.
- **Soft reset** first flushes trailing zero bytes, sending each byte only while DREQ is high. It then sets the reset bit in the mode register and waits a short settle time before it waits for DREQ.
- **Abort** sets the cancel bit and polls the header-status register until it reads zero, with a bounded timeout. It then performs the soft reset without a flush.

All delays are counted in host clock cycles. The counts come from the host clock frequency and from nanosecond parameters. A DREQ wait that runs too long sets a sticky error flag.

Top module: `dec_reset_seq`

## Requirements
- R1: After the synchronous reset, dec_rst_n is 0, and busy, done, wdog_err, wr_req, rd_req and zb_valid are all 0.
- R2: start_init drives dec_rst_n low for at least RST_NS worth of host cycles and then releases it to 1.
- R3: After the hardware reset, no control write is issued until the synchronised DREQ is high. The first write is address 3 with data 0x9800 (clock multiplier 3.0).
- R4: The clock write is followed, in order, by address 0 = MODE_INIT, address 2 = BASS_INIT and address 11 = VOL_INIT. After these the block shows done=1 and busy=0.
- R5: A write request stays asserted, with stable address and data, until wr_ack.
- R6: start_softreset first sends exactly ZERO_BYTES beats of data 0x00. zb_valid is only asserted while the synchronised DREQ is high, so it drops within 3 cycles of DREQ falling.
- R7: After the flush, the block writes address 0 with MODE_INIT with bit 2 (0x0004) set.
- R8: After that reset write is acknowledged, at least SETTLE_NS worth of cycles pass before DREQ is sampled. done is then set only once DREQ is high.
- R9: start_abort writes address 0 with MODE_INIT with bit 3 (0x0008) set. It then reads address 9 repeatedly until the data returned is 0, then performs the reset write of R7 without any zero-byte flush.
- R10: If the header status never reads zero, the reset write of R7 is issued once TIMEOUT_NS worth of cycles have passed after the cancel write.
- R11: If DREQ does not go high within WDOG_NS worth of cycles during a DREQ wait, wdog_err rises and stays 1 until reset. The block then returns to idle with busy=0 and done=0.
- R12: Command pulses that arrive while busy=1 have no effect on the sequence or on the writes issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| start_init | input | 1 | Pulse: run the hardware bring-up sequence |
| start_softreset | input | 1 | Pulse: flush zeros, then software reset |
| start_abort | input | 1 | Pulse: cancel playback, then software reset |
| dreq_in | input | 1 | Decoder data request, asynchronous |
| wr_req | output | 1 | Control write request |
| wr_addr | output | 4 | Control register address |
| wr_data | output | 16 | Control write data |
| wr_ack | input | 1 | Control write accepted |
| rd_req | output | 1 | Header-status read request |
| rd_addr | output | 4 | Read register address (fixed at 9) |
| rd_data | input | 16 | Read data, valid with rd_ack |
| rd_ack | input | 1 | Read completed |
| zb_valid | output | 1 | Zero byte available for the data port |
| zb_data | output | 8 | Data byte (always 0x00) |
| zb_ready | input | 1 | Data port accepts the byte |
| dec_rst_n | output | 1 | Active-low decoder hardware reset |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last sequence finished without error |
| wdog_err | output | 1 | Sticky DREQ-wait watchdog error |

## Verification
A wrong state in this sequencer shows up at the write port as a missing, extra or reordered register write. The scoreboard catches this on the first handshake that departs from the expected list. A bad state can also show as a byte pushed while DREQ is low, which is caught within three cycles of the drop. A timer or counter that is off shows as a wrong count of zero bytes, or as a settle, timeout or reset-pulse interval that is too short, each measured between port events. A broken watchdog path shows as wdog_err staying low, or as busy never falling, once the DREQ wait window has passed.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HWRST,
        S_BOOTWAIT,
        S_CFG,
        S_FLUSH,
        S_SRST_WR,
        S_SETTLE,
        S_SRSTWAIT,
        S_CANCEL_WR,
        S_POLL
    } seq_state_e;

    typedef struct packed {
        logic [3:0]  addr;
        logic [15:0] data;
    } wr_item_t;

    localparam logic [3:0]  REG_MODE  = 4'h0;
    localparam logic [3:0]  REG_BASS  = 4'h2;
    localparam logic [3:0]  REG_CLOCK = 4'h3;
    localparam logic [3:0]  REG_HDR   = 4'h9;
    localparam logic [3:0]  REG_VOL   = 4'hB;
    localparam int          MODE_SRST_BIT   = 2;
    localparam int          MODE_CANCEL_BIT = 3;
    localparam logic [15:0] CLOCK_X3  = 16'h9800;

    // Cycles covering ns at hz, rounded up, never below one.
    function automatic longint unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

    // Configuration write list, clock multiplier first.
    function automatic wr_item_t cfg_item(logic [1:0] idx, logic [15:0] mode_v,
                                          logic [15:0] bass_v, logic [15:0] vol_v);
        wr_item_t it;
        case (idx)
            2'd0:    it = '{addr: REG_CLOCK, data: CLOCK_X3};
            2'd1:    it = '{addr: REG_MODE,  data: mode_v};
            2'd2:    it = '{addr: REG_BASS,  data: bass_v};
            default: it = '{addr: REG_VOL,   data: vol_v};
        endcase
        return it;
    endfunction

endpackage

// File: rtl/dseq_sync2.sv
module dseq_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dseq_timer.sv
module dseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R8/R10/R11 time bases: an unloaded running count drops by one per cycle
    p_tmr_dec_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dec_reset_seq.sv
module dec_reset_seq
    import dseq_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 50_000_000,
    parameter longint unsigned RST_NS     = 10_000,
    parameter longint unsigned SETTLE_NS  = 2_000,
    parameter longint unsigned TIMEOUT_NS = 2_000_000_000,
    parameter longint unsigned WDOG_NS    = 20_000_000,
    parameter int              ZERO_BYTES = 2048,
    parameter logic [15:0]     MODE_INIT  = 16'h0800,
    parameter logic [15:0]     BASS_INIT  = 16'h0000,
    parameter logic [15:0]     VOL_INIT   = 16'h2020
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_init,
    input  logic        start_softreset,
    input  logic        start_abort,
    input  logic        dreq_in,
    output logic        wr_req,
    output logic [3:0]  wr_addr,
    output logic [15:0] wr_data,
    input  logic        wr_ack,
    output logic        rd_req,
    output logic [3:0]  rd_addr,
    input  logic [15:0] rd_data,
    input  logic        rd_ack,
    output logic        zb_valid,
    output logic [7:0]  zb_data,
    input  logic        zb_ready,
    output logic        dec_rst_n,
    output logic        busy,
    output logic        done,
    output logic        wdog_err
);
    localparam longint unsigned RST_CYC  = ns_to_cyc(CLK_HZ, RST_NS);
    localparam longint unsigned SET_CYC  = ns_to_cyc(CLK_HZ, SETTLE_NS);
    localparam longint unsigned TMO_CYC  = ns_to_cyc(CLK_HZ, TIMEOUT_NS);
    localparam longint unsigned WDG_CYC  = ns_to_cyc(CLK_HZ, WDOG_NS);
    localparam longint unsigned MAX_A    = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
    localparam longint unsigned MAX_B    = (TMO_CYC > WDG_CYC) ? TMO_CYC : WDG_CYC;
    localparam longint unsigned MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int              TW       = $clog2(MAX_CYC + 1);
    localparam int              ZW       = $clog2(ZERO_BYTES + 1);
    localparam logic [ZW-1:0]   ZLAST    = ZW'(ZERO_BYTES - 1);
    localparam logic [15:0]     MODE_SRST   = MODE_INIT | (16'h1 << MODE_SRST_BIT);
    localparam logic [15:0]     MODE_CANCEL = MODE_INIT | (16'h1 << MODE_CANCEL_BIT);

    logic          dreq_s;
    seq_state_e    state_q, state_d;
    logic [1:0]    idx_q;
    logic [ZW-1:0] zcnt_q;
    logic          done_q, err_q, rstn_q;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          start_any, set_done, set_err;
    wr_item_t      wr_item;

    dseq_sync2 #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(dreq_in), .q(dreq_s)
    );

    dseq_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    assign start_any = start_init || start_softreset || start_abort;

    // Next-state logic: commands are only looked at in idle.
    always_comb begin
        state_d  = state_q;
        set_done = 1'b0;
        set_err  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start_init)           state_d = S_HWRST;
                else if (start_softreset) state_d = S_FLUSH;
                else if (start_abort)     state_d = S_CANCEL_WR;
            end
            S_HWRST:    if (tmr_exp) state_d = S_BOOTWAIT;
            S_BOOTWAIT: begin
                if (dreq_s)       state_d = S_CFG;
                else if (tmr_exp) begin state_d = S_IDLE; set_err = 1'b1; end
            end
            S_CFG: if (wr_ack && idx_q == 2'd3) begin state_d = S_IDLE; set_done = 1'b1; end
            S_FLUSH: if (zb_valid && zb_ready && zcnt_q == ZLAST) state_d = S_SRST_WR;
            S_SRST_WR:   if (wr_ack) state_d = S_SETTLE;
            S_SETTLE:    if (tmr_exp) state_d = S_SRSTWAIT;
            S_SRSTWAIT: begin
                if (dreq_s)       begin state_d = S_IDLE; set_done = 1'b1; end
                else if (tmr_exp) begin state_d = S_IDLE; set_err = 1'b1; end
            end
            S_CANCEL_WR: if (wr_ack) state_d = S_POLL;
            S_POLL: if ((rd_ack && rd_data == 16'h0000) || tmr_exp) state_d = S_SRST_WR;
            default: state_d = S_IDLE;
        endcase
    end

    // The timer is reloaded on every state change with the new state's window.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_HWRST:               tmr_val = TW'(RST_CYC);
            S_BOOTWAIT, S_SRSTWAIT: tmr_val = TW'(WDG_CYC);
            S_SETTLE:              tmr_val = TW'(SET_CYC);
            S_POLL:                tmr_val = TW'(TMO_CYC);
            default:               tmr_val = '0;
        endcase
    end

    always_comb begin
        case (state_q)
            S_CFG:       wr_item = cfg_item(idx_q, MODE_INIT, BASS_INIT, VOL_INIT);
            S_SRST_WR:   wr_item = '{addr: REG_MODE, data: MODE_SRST};
            S_CANCEL_WR: wr_item = '{addr: REG_MODE, data: MODE_CANCEL};
            default:     wr_item = '0;
        endcase
    end

    assign wr_req    = (state_q == S_CFG) || (state_q == S_SRST_WR) || (state_q == S_CANCEL_WR);
    assign wr_addr   = wr_item.addr;
    assign wr_data   = wr_item.data;
    assign rd_req    = (state_q == S_POLL);
    assign rd_addr   = REG_HDR;
    assign zb_valid  = (state_q == S_FLUSH) && dreq_s;
    assign zb_data   = 8'h00;
    assign dec_rst_n = rstn_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign wdog_err  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            zcnt_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rstn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_any) begin
                done_q <= 1'b0;
                idx_q  <= '0;
                zcnt_q <= '0;
            end
            if (set_done) done_q <= 1'b1;
            if (set_err)  err_q  <= 1'b1;
            if (state_d == S_HWRST)                        rstn_q <= 1'b0;
            else if (state_q == S_HWRST)                   rstn_q <= 1'b1;
            if (state_q == S_CFG && wr_ack)                idx_q  <= idx_q + 2'd1;
            if (zb_valid && zb_ready)                      zcnt_q <= (zcnt_q == ZLAST) ? '0 : zcnt_q + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    p_hwrst_low_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HWRST) |-> !dec_rst_n);

    p_cfg_after_dreq_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CFG && $past(state_q) == S_BOOTWAIT) |-> $past(dreq_s));

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    p_flush_count_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SRST_WR && $past(state_q) == S_FLUSH) |-> ($past(zcnt_q) == ZLAST));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        wdog_err |=> wdog_err);
endmodule

// File: tb/tb_dec_reset_seq.sv
module tb_dec_reset_seq;
    // Timing windows shortened for simulation: 100-cycle reset pulse, 20-cycle settle,
    // 10000-cycle cancel timeout, 20000-cycle DREQ watchdog, 64 flush bytes.
    localparam int RST_C = 100, SET_C = 20, TMO_C = 10000, WDG_C = 20000, NZB = 64;
    localparam logic [15:0] MODE_V = 16'h0800, BASS_V = 16'h0000, VOL_V = 16'h2020;

    logic clk = 1'b0, rst = 1'b1;
    logic start_init = 0, start_softreset = 0, start_abort = 0, dreq_in = 0;
    logic wr_req, rd_req, zb_valid, dec_rst_n, busy, done, wdog_err;
    logic [3:0] wr_addr, rd_addr;
    logic [15:0] wr_data;
    logic [7:0] zb_data;
    logic wr_ack = 0, rd_ack = 0, zb_ready = 1;
    logic [15:0] rd_data = '0;

    always #10 clk = ~clk;

    dec_reset_seq #(
        .CLK_HZ(10_000_000), .RST_NS(10_000), .SETTLE_NS(2_000),
        .TIMEOUT_NS(1_000_000), .WDOG_NS(2_000_000), .ZERO_BYTES(NZB),
        .MODE_INIT(MODE_V), .BASS_INIT(BASS_V), .VOL_INIT(VOL_V)
    ) dut (
        .clk(clk), .rst(rst), .start_init(start_init), .start_softreset(start_softreset),
        .start_abort(start_abort), .dreq_in(dreq_in), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_ack(rd_ack), .zb_valid(zb_valid), .zb_data(zb_data),
        .zb_ready(zb_ready), .dec_rst_n(dec_rst_n), .busy(busy), .done(done),
        .wdog_err(wdog_err)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];
    int wr_cnt = 0, rd_cnt = 0, zb_cnt = 0, srst_cnt = 0;
    int t_srst = 0, t_cancel = 0, hdr_left = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic expect_wr(input logic [3:0] a, input logic [15:0] d, input string req);
        exp_q.push_back({a, d});
        tag_q.push_back(req);
    endtask

    // Decoder model and scoreboard monitor, all on the falling edge.
    always @(negedge clk) begin
        if (wr_req && !wr_ack) begin
            wr_ack <= 1'b1;
            wr_cnt++;
            if (wr_addr == 4'h0 && wr_data[3]) t_cancel = cyc;
            if (wr_addr == 4'h0 && wr_data[2]) begin t_srst = cyc; srst_cnt++; end
            if (exp_q.size() == 0) begin
                check(0, "R12", "unexpected write", {wr_addr, wr_data}, 0);
            end else begin
                automatic logic [19:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({wr_addr, wr_data} == e, t, "write addr/data", {wr_addr, wr_data}, e);
            end
        end else wr_ack <= 1'b0;
        if (rd_req && !rd_ack) begin
            rd_ack <= 1'b1;
            rd_cnt++;
            if (rd_addr != 4'h9) check(0, "R9", "read address", rd_addr, 9);
            if (hdr_left > 0) begin rd_data <= 16'h1234; hdr_left--; end
            else rd_data <= 16'h0000;
        end else rd_ack <= 1'b0;
        if (zb_valid && zb_ready) begin
            zb_cnt++;
            if (zb_data != 8'h00) check(0, "R6", "zero byte data", zb_data, 0);
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic wait_done(input int limit, output int t);
        t = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (!busy) begin t = cyc; break; end
        end
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: bench did not finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        int t, lowc, zb0, rd0, wr0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(dec_rst_n == 0 && busy == 0 && done == 0 && wdog_err == 0 &&
              wr_req == 0 && rd_req == 0 && zb_valid == 0, "R1", "reset outputs",
              {dec_rst_n, busy, done, wdog_err, wr_req, rd_req, zb_valid}, 0);

        // ---- Initialisation with DREQ held low, stray commands while busy ----
        expect_wr(4'h3, 16'h9800, "R3");
        expect_wr(4'h0, MODE_V, "R4");
        expect_wr(4'h2, BASS_V, "R4");
        expect_wr(4'hB, VOL_V, "R4");
        dreq_in = 0;
        pulse(start_init);
        pulse(start_abort);       // R12: ignored while busy
        pulse(start_softreset);   // R12: ignored while busy
        lowc = 4;
        while (!dec_rst_n && lowc < 1000) begin @(negedge clk); lowc++; end
        check(lowc >= RST_C && lowc < 1000, "R2", "reset pulse length", lowc, RST_C);
        repeat (50) @(negedge clk);
        check(wr_cnt == 0 && busy, "R3", "write before DREQ", wr_cnt, 0);
        dreq_in = 1;
        wait_done(2000, t);
        check(done == 1 && t >= 0, "R4", "done after config", done, 1);
        check(exp_q.size() == 0 && wr_cnt == 4, "R12", "write count after init", wr_cnt, 4);
        check(dec_rst_n == 1, "R2", "reset released", dec_rst_n, 1);

        // ---- Soft reset with flush, DREQ dropped mid-flush ----
        expect_wr(4'h0, MODE_V | 16'h0004, "R7");
        zb0 = zb_cnt;
        pulse(start_softreset);
        check(done == 0, "R8", "done cleared on start", done, 0);
        for (int i = 0; i < 2000 && zb_cnt - zb0 < 20; i++) @(negedge clk);
        dreq_in = 0;
        repeat (3) @(negedge clk);
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin @(negedge clk); if (zb_valid) seen++; end
            check(seen == 0, "R6", "zero byte while DREQ low", seen, 0);
        end
        dreq_in = 1;
        wait_done(2000, t);
        check(zb_cnt - zb0 == NZB, "R6", "flush byte count", zb_cnt - zb0, NZB);
        check(srst_cnt == 1 && exp_q.size() == 0, "R7", "reset write issued", srst_cnt, 1);
        check(t - t_srst >= SET_C, "R8", "settle before DREQ sample", t - t_srst, SET_C);
        check(done == 1, "R8", "done after soft reset", done, 1);

        // ---- Abort: header reads nonzero three times ----
        expect_wr(4'h0, MODE_V | 16'h0008, "R9");
        expect_wr(4'h0, MODE_V | 16'h0004, "R9");
        hdr_left = 3; rd0 = rd_cnt; zb0 = zb_cnt;
        pulse(start_abort);
        for (int i = 0; i < 2000 && srst_cnt < 2; i++) @(negedge clk);
        dreq_in = 0;
        repeat (40) @(negedge clk);
        check(done == 0 && busy == 1, "R8", "waits for DREQ after reset", {done, busy}, 1);
        dreq_in = 1;
        wait_done(2000, t);
        check(rd_cnt - rd0 == 4, "R9", "header polls", rd_cnt - rd0, 4);
        check(zb_cnt == zb0, "R9", "no flush on abort", zb_cnt - zb0, 0);
        check(done == 1 && exp_q.size() == 0, "R9", "abort completes", done, 1);

        // ---- Abort with header never clearing: timeout path ----
        expect_wr(4'h0, MODE_V | 16'h0008, "R10");
        expect_wr(4'h0, MODE_V | 16'h0004, "R10");
        hdr_left = 1_000_000;
        pulse(start_abort);
        wait_done(15000, t);
        check(srst_cnt == 3, "R10", "reset after timeout", srst_cnt, 3);
        check(t_srst - t_cancel >= TMO_C, "R10", "timeout length", t_srst - t_cancel, TMO_C);
        check(done == 1, "R10", "done after timeout", done, 1);
        hdr_left = 0;

        // ---- DREQ never rises: watchdog ----
        dreq_in = 0; wr0 = wr_cnt;
        pulse(start_init);
        wait_done(RST_C + WDG_C + 500, t);
        check(t >= 0 && busy == 0, "R11", "busy after watchdog", busy, 0);
        check(wdog_err == 1, "R11", "watchdog flag", wdog_err, 1);
        check(done == 0, "R11", "done after watchdog", done, 0);
        check(wr_cnt == wr0, "R11", "writes during failed init", wr_cnt - wr0, 0);
        repeat (5) @(negedge clk);
        check(wdog_err == 1, "R11", "watchdog flag sticky", wdog_err, 1);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule